// File: doc/BRIEF.md
# Partitioned SRAM Chip-Enable Decoder

This block sits between an 8051-style CPU core and a byte-wide, non-multiplexed SRAM bus. For each cycle it takes the 16-bit address and the access kind (opcode fetch, data read, data write or idle). From these it produces active-low SRAM chip enables, a copy of the first enable that has no battery backing, four peripheral enables, an active-low write enable, and a flag. The flag sends any access that the SRAM does not serve to the multiplexed expansion bus.

A memory-size pin selects the SRAM arrangement. The block drives either four 32k×8 parts or one 128k×8 part. For the 128k part, the second and third enables become upper address bits. A small set of configuration registers selects the remaining options. One option is a shared program/data space split on a 4k boundary, in which writes below the boundary are blocked. Another option sends data accesses to a separate peripheral space. A supply-state input forces every enable inactive during low-supply reset and during battery backup.

The decode is combinational. Only the configuration registers are clocked.

Top module: `sram_ce_decoder`

## Requirements
- R1: On reset, the configuration becomes shared space on, boundary 16 (all program) and peripheral space off. Immediately after reset, with the 32k size selected, a data write at 1234h asserts enable 1 and leaves the write enable high.
- R2: With the 32k size (`mem_32k`=1) and shared space off, fetches below 8000h assert enable 1 and fetches from 8000h assert enable 2. Data accesses below 8000h assert enable 3 and data accesses from 8000h assert enable 4. No more than one enable is low at a time.
- R3: With the 128k size (`mem_32k`=0), any SRAM access drives `ce_n[0]` low. `ce_n[1]` carries physical A16, which is 1 for data space. `ce_n[2]` carries A15, which equals address bit 15. `ce_n[3]` stays high.
- R4: A shared-space request is ignored while the 128k size is selected. Data writes go to data space and are never blocked.
- R5: In shared-space mode, address bit 15 selects between enable 1 and enable 2. A fetch at or above boundary×4096 asserts no enable and raises `exp_bus`. Data reads below the boundary reach the SRAM.
- R6: In shared-space mode, a data write below boundary×4096 keeps `we_n` high while its enable is still asserted. A write at or above the boundary drives `we_n` low. A boundary of 0 makes everything data, and a boundary of 16 makes everything program.
- R7: A configuration load takes effect at the rising edge where `cfg_load` is 1. Before that edge, the outputs follow the old configuration.
- R8: With peripheral space on, data accesses assert `pe_n[addr[15:14]]` and assert no `ce_n`. Writes drive `we_n` low. Fetches still decode to the SRAM.
- R9: While the supply is normal, `ce1_nb_n` equals `ce_n[0]`.
- R10: With supply state 01 (low-supply reset), all `ce_n`, `pe_n`, `ce1_nb_n` and `we_n` are 1 and `exp_bus` is 0.
- R11: With supply state 10 or 11 (battery backup), the outputs are the same as for R10.
- R12: An idle access (kind 00) asserts nothing. `we_n` goes low only for data writes, which use kind 11. Fetch is kind 01 and data read is kind 10. Supply state 00 is normal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration registers |
| rst_n | input | 1 | Active-low reset |
| mem_32k | input | 1 | 1: four 32k SRAMs, 0: one 128k SRAM |
| supply | input | 2 | 00 normal, 01 low-supply reset, 1x battery backup |
| cfg_load | input | 1 | Load configuration at this clock edge |
| cfg_bound | input | 5 | Program/data boundary in 4k pages, 0 to 16 |
| cfg_shared | input | 1 | Request shared program/data space |
| cfg_periph | input | 1 | Route data accesses to peripheral space |
| acc_kind | input | 2 | 00 idle, 01 fetch, 10 data read, 11 data write |
| addr | input | 16 | Access address |
| ce_n | output | 4 | SRAM enables (A16/A15 in 128k mode) |
| ce1_nb_n | output | 1 | Non-backed copy of `ce_n[0]` |
| pe_n | output | 4 | Peripheral enables |
| we_n | output | 1 | Active-low write enable |
| exp_bus | output | 1 | Access belongs on the expansion bus |

## Verification
The address, access kind, size pin and supply state reach every output in the same cycle, through logic alone. The bench changes these inputs at the falling edge and samples one nanosecond later, well before the next rising edge. A configuration load acts only at the following rising edge. For that case the bench checks once with the load pending, to confirm the old behaviour still holds, and again just after the edge, to confirm the new behaviour.

// File: rtl/sced_pkg.sv
package sced_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_FETCH = 2'b01,
    ACC_RD    = 2'b10,
    ACC_WR    = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    SUP_NORMAL = 2'b00,
    SUP_LOWVCC = 2'b01,
    SUP_BACKUP = 2'b10,
    SUP_BACKX  = 2'b11
  } supply_e;

  typedef enum logic [1:0] {
    TGT_NONE   = 2'b00,
    TGT_SRAM   = 2'b01,
    TGT_PERIPH = 2'b10,
    TGT_EXP    = 2'b11
  } tgt_e;
endpackage

// File: rtl/sced_cfg_regs.sv
module sced_cfg_regs
  import sced_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_load,
  input  logic [PAGE_W:0] cfg_bound,
  input  logic            cfg_shared,
  input  logic            cfg_periph,
  output logic [PAGE_W:0] bound_q,
  output logic            shared_q,
  output logic            periph_q
);
  localparam logic [PAGE_W:0] ALL_PROG = (PAGE_W+1)'(1 << PAGE_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bound_q  <= ALL_PROG;
      shared_q <= 1'b1;
      periph_q <= 1'b0;
    end else if (cfg_load) begin
      bound_q  <= cfg_bound;
      shared_q <= cfg_shared;
      periph_q <= cfg_periph;
    end
  end

  // R7: configuration only moves on a load edge
  p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable({bound_q, shared_q, periph_q}));
endmodule

// File: rtl/sced_region_map.sv
module sced_region_map
  import sced_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  acc_kind_e         kind,
  input  logic              mem_32k,
  input  logic              shared_q,
  input  logic              periph_q,
  input  logic [PAGE_W:0]   bound_q,
  output tgt_e              tgt,
  output logic              data_space,
  output logic              wr_allow,
  output logic              shared_eff,
  output logic              in_prog
);
  // page index of the address compared with the boundary page count
  function automatic logic f_below(input logic [ADDR_W-1:0] a,
                                   input logic [PAGE_W:0] b);
    logic [PAGE_W:0] pg;
    pg = {1'b0, a[ADDR_W-1 -: PAGE_W]};
    return pg < b;
  endfunction

  always_comb begin
    shared_eff = shared_q & mem_32k;
    in_prog    = f_below(addr, bound_q);
    tgt        = TGT_NONE;
    data_space = 1'b0;
    unique case (kind)
      ACC_IDLE:  tgt = TGT_NONE;
      ACC_FETCH: tgt = (shared_eff && !in_prog) ? TGT_EXP : TGT_SRAM;
      default: begin
        if (periph_q) tgt = TGT_PERIPH;
        else begin
          tgt        = TGT_SRAM;
          data_space = !shared_eff;
        end
      end
    endcase
    wr_allow = (kind == ACC_WR) &&
               !(tgt == TGT_SRAM && shared_eff && in_prog);
  end

  // R8: fetches never go to peripheral space
  p_fetch_not_periph_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_FETCH) |-> (tgt != TGT_PERIPH));
  // R5: data accesses are always mapped locally
  p_data_not_exp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_RD || kind == ACC_WR) |-> (tgt != TGT_EXP));
endmodule

// File: rtl/sced_enable_gen.sv
module sced_enable_gen
  import sced_pkg::*;
#(
  parameter int NUM_PE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tgt_e              tgt,
  input  logic              data_space,
  input  logic              addr_hi,
  input  logic [$clog2(NUM_PE)-1:0] pe_sel,
  input  logic              wr_allow,
  input  logic              mem_32k,
  input  supply_e           supply,
  output logic [3:0]        ce_n,
  output logic              ce1_nb_n,
  output logic [NUM_PE-1:0] pe_n,
  output logic              we_n,
  output logic              exp_bus
);
  localparam int SEL_W = $clog2(NUM_PE);

  logic              supply_ok;
  logic [3:0]        ce32_raw;
  logic [3:0]        ce128_raw;
  logic [3:0]        ce_raw;
  logic [NUM_PE-1:0] pe_raw;
  logic              to_sram;

  assign supply_ok = (supply == SUP_NORMAL);
  assign to_sram   = (tgt == TGT_SRAM);

  for (genvar g = 0; g < 4; g++) begin : g_ce32
    assign ce32_raw[g] = !(to_sram && ({data_space, addr_hi} == 2'(g)));
  end

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    assign pe_raw[g] = !(tgt == TGT_PERIPH && pe_sel == SEL_W'(g));
  end

  // 128k: enable 1 is chip select, enables 2/3 become A16/A15
  assign ce128_raw = to_sram ? {1'b1, addr_hi, data_space, 1'b0} : 4'b1111;
  assign ce_raw    = mem_32k ? ce32_raw : ce128_raw;

  assign ce_n     = supply_ok ? ce_raw : 4'b1111;
  assign ce1_nb_n = supply_ok ? ce_raw[0] : 1'b1;
  assign pe_n     = supply_ok ? pe_raw : {NUM_PE{1'b1}};
  assign we_n     = supply_ok ? !wr_allow : 1'b1;
  assign exp_bus  = supply_ok && (tgt == TGT_EXP);

  // R10, R11: every enable idle when supply is not normal
  p_supply_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> (&{ce_n, pe_n, we_n, ce1_nb_n}) && !exp_bus);
  // R3: enable 4 unused in 128k mode
  p_ce4_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_32k |-> ce_n[3]);
endmodule

// File: rtl/sram_ce_decoder.sv
module sram_ce_decoder
  import sced_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 4,
  parameter int NUM_PE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_32k,
  input  logic [1:0]        supply,
  input  logic              cfg_load,
  input  logic [PAGE_W:0]   cfg_bound,
  input  logic              cfg_shared,
  input  logic              cfg_periph,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] addr,
  output logic [3:0]        ce_n,
  output logic              ce1_nb_n,
  output logic [NUM_PE-1:0] pe_n,
  output logic              we_n,
  output logic              exp_bus
);
  localparam int SEL_W = $clog2(NUM_PE);

  logic [PAGE_W:0] bound_q;
  logic            shared_q;
  logic            periph_q;
  tgt_e            tgt;
  logic            data_space;
  logic            wr_allow;
  logic            shared_eff;
  logic            in_prog;
  acc_kind_e       kind;
  supply_e         sup;

  assign kind = acc_kind_e'(acc_kind);
  assign sup  = supply_e'(supply);

  sced_cfg_regs #(.PAGE_W(PAGE_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_bound(cfg_bound),
    .cfg_shared(cfg_shared), .cfg_periph(cfg_periph),
    .bound_q(bound_q), .shared_q(shared_q), .periph_q(periph_q)
  );

  sced_region_map #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_map (
    .clk(clk), .rst_n(rst_n), .addr(addr), .kind(kind), .mem_32k(mem_32k),
    .shared_q(shared_q), .periph_q(periph_q), .bound_q(bound_q),
    .tgt(tgt), .data_space(data_space), .wr_allow(wr_allow),
    .shared_eff(shared_eff), .in_prog(in_prog)
  );

  sced_enable_gen #(.NUM_PE(NUM_PE)) u_en (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .data_space(data_space),
    .addr_hi(addr[ADDR_W-1]), .pe_sel(addr[ADDR_W-1 -: SEL_W]),
    .wr_allow(wr_allow), .mem_32k(mem_32k), .supply(sup),
    .ce_n(ce_n), .ce1_nb_n(ce1_nb_n), .pe_n(pe_n), .we_n(we_n),
    .exp_bus(exp_bus)
  );

  // R2: at most one 32k part selected
  p_onehot_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_32k |-> $onehot0(~ce_n));
  // R9: non-backed copy tracks enable 1 on good supply
  p_ce1_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (supply == 2'b00) |-> (ce1_nb_n == ce_n[0]));
  // R8: peripheral and SRAM enables never active together
  p_pe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(&pe_n) |-> (&ce_n) && $onehot0(~pe_n));
  // R12: write strobe only on data writes
  p_we_only_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind != 2'b11) |-> we_n);
  // R6: a blocked write leaves the part enabled but not written
  p_protect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_kind == 2'b11 && shared_eff && in_prog && !periph_q) |-> we_n);
  // R5: expansion flag excludes every local enable
  p_exp_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exp_bus |-> (&ce_n) && (&pe_n));
endmodule

// File: tb/tb_sram_ce_decoder.sv
module tb_sram_ce_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_32k = 1'b1;
  logic [1:0]  supply = 2'b00;
  logic        cfg_load = 1'b0;
  logic [4:0]  cfg_bound = 5'd16;
  logic        cfg_shared = 1'b1;
  logic        cfg_periph = 1'b0;
  logic [1:0]  acc_kind = 2'b00;
  logic [15:0] addr = 16'h0;
  logic [3:0]  ce_n;
  logic        ce1_nb_n;
  logic [3:0]  pe_n;
  logic        we_n;
  logic        exp_bus;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  localparam logic [1:0] K_IDLE = 2'b00, K_FETCH = 2'b01, K_RD = 2'b10, K_WR = 2'b11;
  localparam logic [10:0] ALL_OFF = 11'b1111_1_1111_1_0;

  always #2.5 clk = ~clk;

  sram_ce_decoder dut (
    .clk(clk), .rst_n(rst_n), .mem_32k(mem_32k), .supply(supply),
    .cfg_load(cfg_load), .cfg_bound(cfg_bound), .cfg_shared(cfg_shared),
    .cfg_periph(cfg_periph), .acc_kind(acc_kind), .addr(addr),
    .ce_n(ce_n), .ce1_nb_n(ce1_nb_n), .pe_n(pe_n), .we_n(we_n),
    .exp_bus(exp_bus)
  );

  // expected vector on normal supply: {ce, ce1 copy, pe, we, exp}
  function automatic logic [10:0] mk(input logic [3:0] ce, input logic [3:0] pe,
                                     input logic we, input logic xb);
    return {ce, ce[0], pe, we, xb};
  endfunction

  task automatic check(input string req, input logic [10:0] expv);
    logic [10:0] got;
    got = {ce_n, ce1_nb_n, pe_n, we_n, exp_bus};
    checks++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: got %b expected %b (ce,nb,pe,we,exp)", req, got, expv);
    end
  endtask

  task automatic acc(input logic [1:0] k, input logic [15:0] a,
                     input string req, input logic [10:0] expv);
    @(negedge clk);
    acc_kind = k;
    addr = a;
    #1 check(req, expv);
  endtask

  task automatic load_cfg(input logic [4:0] b, input logic sh, input logic pe);
    @(negedge clk);
    cfg_bound = b; cfg_shared = sh; cfg_periph = pe; cfg_load = 1'b1;
    @(posedge clk);
    #1 cfg_load = 1'b0;
  endtask

  task automatic t_reset;
    acc(K_WR,    16'h1234, "R1 write after reset", mk(4'b1110, 4'hF, 1'b1, 1'b0));
    acc(K_FETCH, 16'hF000, "R1 fetch top page",    mk(4'b1101, 4'hF, 1'b1, 1'b0));
  endtask

  task automatic t_32k_split;
    load_cfg(5'd16, 1'b0, 1'b0);
    acc(K_FETCH, 16'h0100, "R2 fetch low",  mk(4'b1110, 4'hF, 1'b1, 1'b0));
    acc(K_FETCH, 16'h9000, "R2 fetch high", mk(4'b1101, 4'hF, 1'b1, 1'b0));
    acc(K_RD,    16'h7FFF, "R2 read low",   mk(4'b1011, 4'hF, 1'b1, 1'b0));
    acc(K_WR,    16'h8000, "R2 write high", mk(4'b0111, 4'hF, 1'b0, 1'b0));
  endtask

  task automatic t_128k;
    mem_32k = 1'b0;
    load_cfg(5'd16, 1'b1, 1'b0);
    acc(K_FETCH, 16'h0000, "R3 fetch 0",     mk(4'b1000, 4'hF, 1'b1, 1'b0));
    acc(K_FETCH, 16'hC000, "R3 fetch C000",  mk(4'b1100, 4'hF, 1'b1, 1'b0));
    acc(K_RD,    16'h4000, "R3 read 4000",   mk(4'b1010, 4'hF, 1'b1, 1'b0));
    acc(K_WR,    16'h8001, "R4 write unblocked", mk(4'b1110, 4'hF, 1'b0, 1'b0));
    acc(K_WR,    16'h0000, "R4 write low unblocked", mk(4'b1010, 4'hF, 1'b0, 1'b0));
    mem_32k = 1'b1;
  endtask

  task automatic t_shared;
    load_cfg(5'd3, 1'b1, 1'b0);
    acc(K_FETCH, 16'h2FFF, "R5 fetch below bound", mk(4'b1110, 4'hF, 1'b1, 1'b0));
    acc(K_FETCH, 16'h3000, "R5 fetch at bound",    ALL_OFF | 11'b1);
    acc(K_RD,    16'h1000, "R5 read program area", mk(4'b1110, 4'hF, 1'b1, 1'b0));
    acc(K_WR,    16'h1000, "R6 write blocked",     mk(4'b1110, 4'hF, 1'b1, 1'b0));
    acc(K_WR,    16'h3000, "R6 write at bound",    mk(4'b1110, 4'hF, 1'b0, 1'b0));
    acc(K_WR,    16'h9000, "R6 write high",        mk(4'b1101, 4'hF, 1'b0, 1'b0));
    load_cfg(5'd0, 1'b1, 1'b0);
    acc(K_FETCH, 16'h0000, "R6 bound 0 fetch",     ALL_OFF | 11'b1);
    acc(K_WR,    16'h0000, "R6 bound 0 write",     mk(4'b1110, 4'hF, 1'b0, 1'b0));
    load_cfg(5'd16, 1'b1, 1'b0);
    acc(K_WR,    16'hFFFF, "R6 bound 16 write",    mk(4'b1101, 4'hF, 1'b1, 1'b0));
    acc(K_FETCH, 16'hFFFF, "R6 bound 16 fetch",    mk(4'b1101, 4'hF, 1'b1, 1'b0));
  endtask

  task automatic t_cfg_timing;
    load_cfg(5'd0, 1'b1, 1'b0);
    @(negedge clk);
    acc_kind = K_WR; addr = 16'h0000;
    cfg_bound = 5'd16; cfg_shared = 1'b1; cfg_periph = 1'b0; cfg_load = 1'b1;
    #1 check("R7 before load edge", mk(4'b1110, 4'hF, 1'b0, 1'b0));
    @(posedge clk);
    #1 cfg_load = 1'b0;
    check("R7 after load edge", mk(4'b1110, 4'hF, 1'b1, 1'b0));
  endtask

  task automatic t_periph;
    load_cfg(5'd16, 1'b0, 1'b1);
    acc(K_RD,    16'h0000, "R8 read PE1",  mk(4'hF, 4'b1110, 1'b1, 1'b0));
    acc(K_WR,    16'h5000, "R8 write PE2", mk(4'hF, 4'b1101, 1'b0, 1'b0));
    acc(K_RD,    16'hBFFF, "R8 read PE3",  mk(4'hF, 4'b1011, 1'b1, 1'b0));
    acc(K_WR,    16'hC000, "R8 write PE4", mk(4'hF, 4'b0111, 1'b0, 1'b0));
    acc(K_FETCH, 16'h0000, "R8 fetch to SRAM", mk(4'b1110, 4'hF, 1'b1, 1'b0));
  endtask

  task automatic t_power;
    load_cfg(5'd0, 1'b1, 1'b0);
    supply = 2'b01;
    acc(K_WR,    16'h8000, "R10 low supply write", ALL_OFF);
    acc(K_FETCH, 16'h4000, "R10 low supply no exp", ALL_OFF);
    supply = 2'b10;
    acc(K_FETCH, 16'h0000, "R11 backup fetch", ALL_OFF);
    supply = 2'b11;
    acc(K_WR,    16'h2000, "R11 backup write", ALL_OFF);
    mem_32k = 1'b0;
    acc(K_RD,    16'hFFFF, "R10 128k held high", ALL_OFF);
    supply = 2'b01;
    acc(K_RD,    16'hFFFF, "R10 128k low supply", ALL_OFF);
    mem_32k = 1'b1;
    supply = 2'b00;
    load_cfg(5'd16, 1'b0, 1'b0);
    acc(K_FETCH, 16'h0000, "R9 copy low",  mk(4'b1110, 4'hF, 1'b1, 1'b0));
    acc(K_RD,    16'h0000, "R9 copy high", mk(4'b1011, 4'hF, 1'b1, 1'b0));
  endtask

  task automatic t_idle;
    acc(K_IDLE, 16'h0000, "R12 idle 32k", ALL_OFF);
    mem_32k = 1'b0;
    acc(K_IDLE, 16'hFFFF, "R12 idle 128k", ALL_OFF);
    mem_32k = 1'b1;
    acc(K_RD,   16'h8000, "R12 read no strobe", mk(4'b0111, 4'hF, 1'b1, 1'b0));
  endtask

  initial begin
    #500000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_32k_split();
    t_128k();
    t_shared();
    t_cfg_timing();
    t_periph();
    t_power();
    t_idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule